// File: doc/BRIEF.md
# Shared Message Interrupt Register Bank

This block holds eight 32-bit message registers that collect inbound message-style interrupts. A producer posts a message by writing one packed word to a single index location. The top three bits of that word pick the register and the next five bits pick the bit inside it. The chosen bit is ORed into the register, and that register's level interrupt line goes high.

A consumer services a line by reading the matching message register. The read returns the accumulated bits. In the same step it clears the register and drops the line. A summary location gives a quick view of which registers currently hold any bits, so software can skip the empty ones.

The port has separate read and write strobes with their own byte offsets, so a post and a clearing read can happen in the same cycle. Read data appears on `rd_data` one cycle after `rd_en` and returns to zero when no read is made.

Top module: `msg_irq_bank`

## Requirements
- R1: A write with `wr_addr` = 0x140 ORs the bit numbered `wr_data[28:24]` into the register numbered `wr_data[31:29]`. Bits already set in that register are kept.
- R2: Such a write drives `irq_o[n]` high from the next cycle, where n is the selected register.
- R3: A read with `rd_addr` = 0x10·n (n = 0..7) returns register n on `rd_data` in the next cycle. The same edge clears the register to zero and drops `irq_o[n]`.
- R4: A read with `rd_addr` = 0x120 returns a word in which bit n is 1 exactly when register n is non-zero, sampled before any change made at that edge. Bits 31:8 of the word are zero.
- R5: A write to any offset other than 0x140 changes no register and no interrupt line.
- R6: When a post and a clearing read target the same register in one cycle, the read returns the old contents. The register then holds only the newly posted bit, and its line stays high.
- R7: A read of any offset not named in R3 or R4 returns zero.
- R8: While `rst_n` is low at a clock edge, all registers, all interrupt lines and `rd_data` are cleared.
- R9: `irq_o[n]` is high exactly when register n is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Byte offset of the write |
| wr_data | input | 32 | Write data (packed register and bit select at 0x140) |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 12 | Byte offset of the read |
| rd_data | output | 32 | Read data, valid one cycle after `rd_en` |
| irq_o | output | 8 | One level interrupt line per message register |

## Verification
The assertions assume that strobes and addresses are clean, known values at every clock edge once reset is released. They also assume that a read and a write may share a cycle only through the separate read and write address fields. The stimulus changes every input on the falling edge only. It holds reset low from time zero until the first checks, and it only issues reads of mapped or deliberately unmapped offsets with known values. Collisions on one register are created on purpose, through the two address fields, in a single cycle.

// File: rtl/msgirq_pkg.sv
// Package: shared constants for the message interrupt register bank.
// Assumes byte offsets; the register stride and special offsets are fixed
// because software depends on them.
package msgirq_pkg;
    localparam int unsigned MSG_STRIDE  = 'h10;   // spacing of message registers
    localparam int unsigned SUMMARY_OFS = 'h120;  // non-empty summary word
    localparam int unsigned INDEX_OFS   = 'h140;  // packed post location
endpackage

// File: rtl/msgirq_wdec.sv
// Module: write decoder. Turns a write to the index location into a one-hot
// register select and a single-bit set mask. Assumes NUM_REGS is a power of
// two and DATA_W >= NUM_REGS; the select fields sit at the top of the word.
module msgirq_wdec #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [NUM_REGS-1:0] set_vec,
    output logic [DATA_W-1:0]   set_mask
);
    import msgirq_pkg::*;

    localparam int SEL_W   = $clog2(NUM_REGS);
    localparam int BIT_W   = $clog2(DATA_W);
    localparam int SEL_LSB = DATA_W - SEL_W;
    localparam int BIT_LSB = SEL_LSB - BIT_W;

    logic               idx_hit;
    logic [SEL_W-1:0]   reg_sel;
    logic [BIT_W-1:0]   bit_sel;
    logic               unused_low;

    assign reg_sel    = wr_data[DATA_W-1 -: SEL_W];
    assign bit_sel    = wr_data[SEL_LSB-1 -: BIT_W];
    assign unused_low = ^wr_data[BIT_LSB-1:0];

    // Purpose: recognise a post to the index location.
    always_comb begin
        idx_hit = wr_en && (wr_addr == ADDR_W'(INDEX_OFS));
    end

    // Purpose: expand the register field into a one-hot select.
    always_comb begin
        set_vec = '0;
        if (idx_hit) begin
            set_vec[reg_sel] = 1'b1;
        end
    end

    // Purpose: expand the bit field into a single-bit mask.
    always_comb begin
        set_mask          = '0;
        set_mask[bit_sel] = 1'b1;
    end

    // R1: at most one register is targeted by a post.
    a_r1_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_vec));
    // R5: a write away from the index location selects nothing.
    a_r5_other_offset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != ADDR_W'(INDEX_OFS)) |-> (set_vec == '0));
endmodule

// File: rtl/msgirq_rdec.sv
// Module: read decoder. Turns a read offset into a one-hot clear select for
// the message registers and a flag for the summary word. Assumes the message
// registers sit below the summary offset.
module msgirq_rdec #(
    parameter int NUM_REGS = 8,
    parameter int ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [NUM_REGS-1:0] clr_vec,
    output logic                sum_sel
);
    import msgirq_pkg::*;

    // Purpose: one comparator per message register offset.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_cmp
        localparam logic [ADDR_W-1:0] OFS = ADDR_W'(i * MSG_STRIDE);
        always_comb begin
            clr_vec[i] = rd_en && (rd_addr == OFS);
        end
    end

    // Purpose: recognise a read of the summary word.
    always_comb begin
        sum_sel = rd_en && (rd_addr == ADDR_W'(SUMMARY_OFS));
    end

    // R3: a read clears at most one register and never with the summary.
    a_r3_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clr_vec, sum_sel}));
endmodule

// File: rtl/msgirq_slot.sv
// Module: one message register with its interrupt line. A set ORs a mask in
// and raises the line; a clear empties the register and drops the line. When
// both arrive together the set wins over the clear for the new bit only.
module msgirq_slot #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [DATA_W-1:0] set_mask,
    input  logic              clr_en,
    output logic [DATA_W-1:0] value,
    output logic              irq
);
    // Purpose: update the register contents and the interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
            irq   <= 1'b0;
        end else if (set_en && clr_en) begin
            value <= set_mask;
            irq   <= 1'b1;
        end else if (clr_en) begin
            value <= '0;
            irq   <= 1'b0;
        end else if (set_en) begin
            value <= value | set_mask;
            irq   <= 1'b1;
        end
    end

    // R2: a post raises the line on the next cycle.
    a_r2_post_raises: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> irq);
    // R3: a plain clear leaves the register empty and the line low.
    a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> (value == '0 && !irq));
    // R1: without a clear, no bit is ever lost.
    a_r1_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> ((value & $past(value)) == $past(value)));
    // R6: a collision keeps only the new bit and the line high.
    a_r6_collision: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && clr_en) |=> (irq && value == $past(set_mask)));
    // R9: the line mirrors a non-empty register.
    a_r9_line_matches: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (value != '0));
endmodule

// File: rtl/msg_irq_bank.sv
// Module: top of the shared message interrupt register bank. Decodes the
// write and read strobes, holds NUM_REGS message registers and registers the
// read data one cycle after the strobe. Assumes reads and writes use their
// own offsets and may share a cycle.
module msg_irq_bank #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic [NUM_REGS-1:0] irq_o
);
    logic [NUM_REGS-1:0] set_vec;
    logic [DATA_W-1:0]   set_mask;
    logic [NUM_REGS-1:0] clr_vec;
    logic                sum_sel;
    logic [DATA_W-1:0]   slot_val [NUM_REGS];
    logic [NUM_REGS-1:0] nonempty;
    logic [DATA_W-1:0]   rd_next;

    msgirq_wdec #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wdec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .set_vec  (set_vec),
        .set_mask (set_mask)
    );

    msgirq_rdec #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_rdec (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .clr_vec (clr_vec),
        .sum_sel (sum_sel)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        msgirq_slot #(.DATA_W(DATA_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_en   (set_vec[i]),
            .set_mask (set_mask),
            .clr_en   (clr_vec[i]),
            .value    (slot_val[i]),
            .irq      (irq_o[i])
        );
        // Purpose: flag a register that holds any bit.
        always_comb begin
            nonempty[i] = (slot_val[i] != '0);
        end
    end

    // Purpose: choose the word returned by this cycle's read.
    always_comb begin
        rd_next = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (clr_vec[i]) begin
                rd_next = rd_next | slot_val[i];
            end
        end
        if (sum_sel) begin
            rd_next = DATA_W'(nonempty);
        end
    end

    // Purpose: register the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_next;
        end
    end

    // R7: a read that hits no mapped offset returns zero.
    a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && clr_vec == '0 && !sum_sel) |=> (rd_data == '0));
    // R4: the summary word never reports a bit above the register count.
    a_r4_summary_width: assert property (@(posedge clk) disable iff (!rst_n)
        sum_sel |=> ((rd_data >> NUM_REGS) == '0));
    // R3: reading a register drops its line unless a post collides.
    a_r3_line_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec != '0 && set_vec == '0) |=> (($past(clr_vec) & irq_o) == '0));
endmodule

// File: tb/sim_msg_irq_bank.sv
// Bench: a scoreboard. The driver task updates a reference model and pushes
// the expected read word; a monitor pops and compares on the falling edge
// after each read.
module sim_msg_irq_bank;
    localparam int NR = 8;
    localparam int DW = 32;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [NR-1:0] irq_o;

    int total = 0;
    int bad = 0;
    logic [DW-1:0] mdl [NR];
    logic [DW-1:0] exp_q [$];
    string         tag_q [$];
    logic          rd_seen = 1'b0;

    always #2 clk = ~clk;

    msg_irq_bank #(.NUM_REGS(NR), .DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] post_word(input int r, input int b);
        return {r[2:0], b[4:0], 24'h5a5a5a};
    endfunction

    always @(posedge clk) rd_seen <= rd_en && rst_n;

    // Monitor: compare each read result against the queued expectation.
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("scoreboard underflow", 32'h1, 32'h0);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    // Driver: one cycle with an optional write and an optional read.
    task automatic bus_cycle(input bit do_wr, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                             input bit do_rd, input logic [AW-1:0] ra, input string tag);
        logic [DW-1:0] e;
        e = '0;
        if (do_rd) begin
            if (ra == 12'h120) begin
                for (int i = 0; i < NR; i++) e[i] = (mdl[i] != '0);
            end else if (ra[3:0] == 4'h0 && ra < 12'(NR * 16)) begin
                e = mdl[ra[6:4]];
                mdl[ra[6:4]] = '0;
            end
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        if (do_wr && wa == 12'h140) begin
            mdl[wd[31:29]] = mdl[wd[31:29]] | (32'h1 << wd[28:24]);
        end
        wr_en = do_wr; wr_addr = wa; wr_data = wd;
        rd_en = do_rd; rd_addr = ra;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic check_irq(input string req);
        logic [NR-1:0] e;
        for (int i = 0; i < NR; i++) e[i] = (mdl[i] != '0);
        check(req, DW'(irq_o), DW'(e));
    endtask

    initial begin
        #(4 * 50000);
        check("watchdog expired", 32'h1, 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NR; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        check("R8 reset rd_data", rd_data, '0);
        check("R8 reset irq", DW'(irq_o), '0);
        rst_n = 1'b1;
        @(negedge clk);

        bus_cycle(0, '0, '0, 1, 12'h120, "R4 empty summary");
        bus_cycle(1, 12'h140, post_word(2, 5), 0, '0, "");
        check_irq("R2 post raises line 2");
        bus_cycle(0, '0, '0, 1, 12'h120, "R4 summary after post");
        bus_cycle(0, '0, '0, 1, 12'h020, "R3 read reg 2");
        check_irq("R3 line 2 drops");
        bus_cycle(0, '0, '0, 1, 12'h020, "R3 reg 2 cleared");

        bus_cycle(1, 12'h140, post_word(7, 0), 0, '0, "");
        bus_cycle(1, 12'h140, post_word(7, 31), 0, '0, "");
        bus_cycle(1, 12'h140, post_word(0, 17), 0, '0, "");
        check_irq("R9 lines follow contents");
        bus_cycle(0, '0, '0, 1, 12'h120, "R4 summary two regs");
        bus_cycle(0, '0, '0, 1, 12'h130, "R7 unmapped 0x130");
        bus_cycle(0, '0, '0, 1, 12'h078, "R7 unmapped 0x078");
        bus_cycle(0, '0, '0, 1, 12'h080, "R7 unmapped 0x080");
        bus_cycle(0, '0, '0, 1, 12'h070, "R1 read reg 7 ORed bits");
        bus_cycle(0, '0, '0, 1, 12'h000, "R3 read reg 0");
        check_irq("R3 all lines low");

        bus_cycle(1, 12'h144, post_word(3, 1), 0, '0, "");
        bus_cycle(1, 12'h030, 32'hffff_ffff, 0, '0, "");
        bus_cycle(1, 12'h120, post_word(3, 2), 0, '0, "");
        check_irq("R5 other offsets ignored lines");
        bus_cycle(0, '0, '0, 1, 12'h120, "R5 summary stays empty");
        bus_cycle(0, '0, '0, 1, 12'h030, "R5 reg 3 untouched");

        bus_cycle(1, 12'h140, post_word(4, 3), 0, '0, "");
        bus_cycle(1, 12'h140, post_word(4, 9), 1, 12'h040, "R6 collision returns old");
        check_irq("R6 line stays high");
        bus_cycle(0, '0, '0, 1, 12'h040, "R6 new bit survives");
        check_irq("R6 line low after second read");

        bus_cycle(1, 12'h140, post_word(5, 12), 0, '0, "");
        bus_cycle(1, 12'h140, post_word(1, 4), 1, 12'h050, "R3 read other reg during post");
        check_irq("R2 line 1 up, line 5 down");
        bus_cycle(0, '0, '0, 1, 12'h010, "R1 reg 1 posted");

        bus_cycle(1, 12'h140, post_word(6, 8), 0, '0, "");
        bus_cycle(0, '0, '0, 1, 12'h060, "R8 pre-reset read");
        bus_cycle(1, 12'h140, post_word(6, 8), 0, '0, "");
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < NR; i++) mdl[i] = '0;
        check("R8 mid reset irq", DW'(irq_o), '0);
        check("R8 mid reset rd_data", rd_data, '0);
        rst_n = 1'b1;
        @(negedge clk);
        bus_cycle(0, '0, '0, 1, 12'h060, "R8 reg 6 cleared by reset");
        @(negedge clk);

        check("R3 scoreboard drained", DW'(exp_q.size()), '0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule